// File: doc/BRIEF.md
# Four-Function ALU with Condition Flags

This block is a combinational arithmetic/logic unit for a simple processor datapath. It takes two operand words, X and Y, and a 2-bit function select. It returns the selected result together with three condition flags: zero, sign and signed overflow. Any change on an input reaches the outputs after gate delay alone. The block has no clock and holds no state.

The surrounding pipeline owns everything else. It decides when the flags are captured into a condition-code register and how instructions map onto the function select. The word width is a parameter and defaults to 32 bits. There is no carry input and no carry output, so wide arithmetic cannot be chained through this unit.

Top module: `alu_cc_unit`

## Requirements
- R1: With func_sel = 0 the result is X + Y, wrapped modulo 2^WIDTH.
- R2: With func_sel = 1 the result is X − Y (Y taken from X), wrapped modulo 2^WIDTH.
- R3: With func_sel = 2 the result is the bitwise AND of X and Y.
- R4: With func_sel = 3 the result is the bitwise XOR of X and Y.
- R5: flag_zero is 1 exactly when every bit of the result is 0, for every function.
- R6: flag_sign equals bit WIDTH−1 of the result, for every function.
- R7: For addition, flag_ovf is 1 exactly when X and Y share a sign and the sign of the result differs from it.
- R8: For subtraction, flag_ovf is 1 exactly when X and Y differ in sign and the sign of the result differs from the sign of X.
- R9: For AND and XOR, flag_ovf is 0 whatever the operands are.
- R10: The outputs follow an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_opnd | input | WIDTH | First operand; the minuend for subtraction |
| y_opnd | input | WIDTH | Second operand; the subtrahend for subtraction |
| func_sel | input | 2 | Function select: 0 add, 1 subtract, 2 AND, 3 XOR |
| result | output | WIDTH | Result of the selected function |
| flag_zero | output | 1 | Result is all zeros |
| flag_sign | output | 1 | Most significant bit of the result |
| flag_ovf | output | 1 | Signed overflow of an add or a subtract |

## Verification
The bench targets the two overflow boundaries in each direction:
- the largest positive value plus one, and the most negative value plus itself;
- the most negative value minus one, and the largest positive value minus minus-one.

A unit that took overflow from the carry out, or that used the addition rule for subtraction, would raise or drop the flag on exactly these vectors. A wrap to an all-zero result combined with overflow checks that the zero flag ignores the lost carry.

Logic operations with the top bit set confirm two further points. The sign flag still tracks the result, and the overflow flag stays clear, which catches a design that leaves the adder's overflow on the output for every function.

Each vector is checked a short time after the inputs change, with no clock edge in between, to show the path is combinational. A long pseudo-random sweep then covers the general case.

// File: rtl/alu_cc_pkg.sv
`timescale 1ns/1ps
package alu_cc_pkg;

  // Function select encoding; the values are part of the interface.
  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;

  function automatic logic fn_is_arith(input alu_fn_e fn);
    return (fn == FN_ADD) || (fn == FN_SUB);
  endfunction

endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             do_sub,
  output logic [WIDTH-1:0] sum_out,
  output logic             ovf_out
);
  localparam int MSB = WIDTH - 1;

  // Two's complement: a - b == a + ~b + 1
  function automatic logic [WIDTH-1:0] eff_operand(input logic [WIDTH-1:0] b,
                                                   input logic sub);
    return sub ? ~b : b;
  endfunction

  function automatic logic [WIDTH-1:0] add_words(input logic [WIDTH-1:0] a,
                                                 input logic [WIDTH-1:0] b,
                                                 input logic cin);
    return a + b + {{(WIDTH-1){1'b0}}, cin};
  endfunction

  // Overflow: the adder's inputs share a sign and the sum's sign differs.
  function automatic logic sign_overflow(input logic a_s, input logic b_s,
                                         input logic r_s);
    return (a_s == b_s) && (r_s != a_s);
  endfunction

  logic [WIDTH-1:0] b_eff;

  always_comb begin
    b_eff   = eff_operand(b_in, do_sub);
    sum_out = add_words(a_in, b_eff, do_sub);
    ovf_out = sign_overflow(a_in[MSB], b_eff[MSB], sum_out[MSB]);
  end
endmodule

// File: rtl/alu_bitwise.sv
`timescale 1ns/1ps
module alu_bitwise #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             pick_xor,
  output logic [WIDTH-1:0] bits_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic and_b;
    logic xor_b;
    assign and_b       = a_in[i] & b_in[i];
    assign xor_b       = a_in[i] ^ b_in[i];
    assign bits_out[i] = pick_xor ? xor_b : and_b;
  end
endmodule

// File: rtl/alu_flag_gen.sv
`timescale 1ns/1ps
module alu_flag_gen #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] res_in,
  input  logic             arith_ovf,
  input  logic             arith_sel,
  output logic             zero_o,
  output logic             sign_o,
  output logic             ovf_o
);
  assign zero_o = ~|res_in;
  assign sign_o = res_in[WIDTH-1];
  assign ovf_o  = arith_sel & arith_ovf;
endmodule

// File: rtl/alu_cc_unit.sv
`timescale 1ns/1ps
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_opnd,
  input  logic [WIDTH-1:0] y_opnd,
  input  logic [1:0]       func_sel,
  output logic [WIDTH-1:0] result,
  output logic             flag_zero,
  output logic             flag_sign,
  output logic             flag_ovf
);
  localparam int MSB = WIDTH - 1;

  alu_fn_e          fn;
  logic [WIDTH-1:0] arith_res;
  logic [WIDTH-1:0] logic_res;
  logic             arith_ovf;
  logic             arith_sel;

  assign fn        = alu_fn_e'(func_sel);
  assign arith_sel = fn_is_arith(fn);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_in   (x_opnd),
    .b_in   (y_opnd),
    .do_sub (fn == FN_SUB),
    .sum_out(arith_res),
    .ovf_out(arith_ovf)
  );

  alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a_in    (x_opnd),
    .b_in    (y_opnd),
    .pick_xor(fn == FN_XOR),
    .bits_out(logic_res)
  );

  assign result = arith_sel ? arith_res : logic_res;

  alu_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .res_in   (result),
    .arith_ovf(arith_ovf),
    .arith_sel(arith_sel),
    .zero_o   (flag_zero),
    .sign_o   (flag_sign),
    .ovf_o    (flag_ovf)
  );

  // Checks that tie the outputs of the separate submodules together.
  always_comb begin
    // R1
    add_result_chk: assert (fn != FN_ADD || (result - y_opnd) == x_opnd);
    // R2
    sub_result_chk: assert (fn != FN_SUB || (result + y_opnd) == x_opnd);
    // R5
    zero_flag_chk: assert (flag_zero == (result == '0));
    // R6
    sign_flag_chk: assert (flag_sign == result[MSB]);
    // R7
    add_ovf_chk: assert (fn != FN_ADD ||
                         flag_ovf == ((x_opnd[MSB] == y_opnd[MSB]) && (result[MSB] != x_opnd[MSB])));
    // R8
    sub_ovf_chk: assert (fn != FN_SUB ||
                         flag_ovf == ((x_opnd[MSB] != y_opnd[MSB]) && (result[MSB] != x_opnd[MSB])));
    // R9
    no_overflow_chk: assert (arith_sel || !flag_ovf);
  end
endmodule

// File: tb/tb_alu_cc_unit.sv
`timescale 1ns/1ps
module tb_alu_cc_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic [W-1:0] x_opnd = '0;
  logic [W-1:0] y_opnd = '0;
  logic [1:0]   func_sel = 2'd0;
  logic [W-1:0] result;
  logic         flag_zero, flag_sign, flag_ovf;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [W-1:0] res;
    logic         z, s, o;
    logic [1:0]   f;
  } exp_t;

  exp_t sb_q[$];

  always #10 clk = ~clk;  // 50 MHz

  alu_cc_unit #(.WIDTH(W)) dut (
    .x_opnd(x_opnd), .y_opnd(y_opnd), .func_sel(func_sel),
    .result(result), .flag_zero(flag_zero), .flag_sign(flag_sign), .flag_ovf(flag_ovf)
  );

  // Independent model: signed arithmetic in 64 bits, range test for overflow.
  function automatic exp_t model(input logic [W-1:0] x, input logic [W-1:0] y,
                                 input logic [1:0] f);
    exp_t e;
    longint sx, sy, wide;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    wide = 0;
    case (f)
      2'd0: begin wide = sx + sy; e.res = x + y; end
      2'd1: begin wide = sx - sy; e.res = x - y; end
      2'd2: e.res = x & y;
      default: e.res = x ^ y;
    endcase
    e.o = (f < 2'd2) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
    e.z = 1'b1;
    for (int i = 0; i < W; i++) if (e.res[i]) e.z = 1'b0;
    e.s = e.res[W-1];
    e.f = f;
    return e;
  endfunction

  function automatic string res_tag(input logic [1:0] f);
    case (f)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic string ovf_tag(input logic [1:0] f);
    case (f)
      2'd0: return "R7";
      2'd1: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input exp_t e, input string pre);
    check({pre, res_tag(e.f)}, result, e.res);
    check({pre, "R5"}, {31'd0, flag_zero}, {31'd0, e.z});
    check({pre, "R6"}, {31'd0, flag_sign}, {31'd0, e.s});
    check({pre, ovf_tag(e.f)}, {31'd0, flag_ovf}, {31'd0, e.o});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Driver: apply at negedge, check the comb path at once (R10), queue expectation.
  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y, input logic [1:0] f);
    exp_t e;
    @(negedge clk);
    x_opnd = x; y_opnd = y; func_sel = f;
    e = model(x, y, f);
    #1;
    check("R10 comb-path ", result, e.res);
    sb_q.push_back(e);
  endtask

  // Monitor: pops one expectation per rising edge.
  initial begin
    forever begin
      @(posedge clk);
      if (sb_q.size() > 0) compare_all(sb_q.pop_front(), "");
    end
  end

  initial begin
    logic [W-1:0] lfsr;
    #5;
    // Idle state: zero operands, add selected
    check("R1 idle result", result, '0);
    check("R5 idle zero", {31'd0, flag_zero}, 32'd1);
    check("R7 idle ovf", {31'd0, flag_ovf}, 32'd0);

    drive(32'd5, 32'd7, 2'd0);                    // R1 plain add
    drive(32'h7FFF_FFFF, 32'd1, 2'd0);            // R7 positive overflow
    drive(32'h8000_0000, 32'h8000_0000, 2'd0);    // R7 + R5 wrap to zero
    drive(32'hFFFF_FFFF, 32'd1, 2'd0);            // R5 zero without overflow
    drive(32'd3, 32'd5, 2'd1);                    // R2 + R6 negative result
    drive(32'h8000_0000, 32'd1, 2'd1);            // R8 negative overflow
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'd1);    // R8 positive overflow
    drive(32'h8000_0000, 32'h8000_0000, 2'd1);    // R8 same sign, no overflow
    drive(32'd9, 32'd9, 2'd1);                    // R5 zero from subtract
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 2'd2);    // R3
    drive(32'hAAAA_AAAA, 32'h5555_5555, 2'd2);    // R3 + R5 zero
    drive(32'hFFFF_FFFF, 32'h8000_0000, 2'd2);    // R9 + R6 sign set, no ovf
    drive(32'h1234_5678, 32'h1234_5678, 2'd3);    // R4 + R5
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'd3);    // R4 + R9 + R6

    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 200; n++) begin
      logic [W-1:0] xa, yb;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      xa = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      yb = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      drive(xa, yb, 2'(n % 4));
    end

    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end

  // Watchdog
  initial begin
    #(20 * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule